// File: doc/BRIEF.md
# Phase-Change Memory Bank Command Timing Tracker

This block sits between a memory scheduler and one phase-change memory bank that has a single row buffer. The scheduler offers one command at a time on a valid/ready handshake. The commands are row open, column read, column write, row close (precharge), powerdown entry and powerdown exit. The block accepts a command only in a cycle where every timing gap that applies to it has run out. Until then it holds `cmd_ready` low, and the scheduler keeps the command in place.

The tracker records which row is open and whether a write has touched it. Closing a clean row is nearly free. Closing a touched row starts a write-back pulse, and the bank stays busy until the pulse ends. The pulse length depends on the kind of pulse the scheduler picks with the close command: a short amorphizing pulse or a long crystallizing pulse. The block also drives two windows for the data path: the cycles in which read data is on the bus and the cycles in which write data is taken. The bank has no refresh.

Top module: `pcm_bank_tracker`

## Requirements
- R1: After reset no row is open, the dirty flag, powered-down flag, both data windows and `refresh_req` are low, and a row-open command is ready at once.
- R2: A read or write is accepted no sooner than 48 cycles after the row-open command that opened its row.
- R3: Closing a dirty row keeps the bank busy for 1 cycle plus the write-back pulse: 40 cycles when `cmd_set_pulse` is 0 and 60 cycles when it is 1. The next row-open is therefore accepted 41 or 61 cycles after the close.
- R4: `rd_data_valid` is high in cycles 1 to 4 after each accepted read.
- R5: Two column commands (reads or writes) are at least 2 cycles apart.
- R6: `wr_data_accept` is high in cycles 4 to 7 after each accepted write. A read is accepted no sooner than 10 cycles after a write, which is the end of write data plus 3 cycles.
- R7: A row-open records `cmd_row` on `open_row` and raises `row_open` with the dirty flag clear. A write sets `row_dirty`. A close clears both `row_open` and `row_dirty`.
- R8: Closing a clean row takes 1 cycle, and no minimum gap applies between row-open and close. A close is accepted no sooner than 3 cycles after a read and 8 cycles after a write.
- R9: Powerdown entry is accepted no sooner than 5 cycles after a read and 68 cycles after a write. Exit is allowed 1 cycle after entry. Any other command is allowed 3 cycles after exit.
- R10: `cmd_op` encodes 0 row-open, 1 read, 2 write, 3 close, 4 powerdown entry and 5 powerdown exit. An illegal command is held off with `cmd_ready` low and is never dropped. This covers a column command with no row open, a row-open while a row is open, and anything but exit while powered down.
- R11: `refresh_req` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 3 | Command code (see R10) |
| cmd_row | input | ROW_W | Row address for row-open |
| cmd_set_pulse | input | 1 | Write-back pulse kind on close: 0 short, 1 long |
| cmd_ready | output | 1 | Offered command is legal this cycle |
| row_open | output | 1 | A row is held in the row buffer |
| open_row | output | ROW_W | Address of the open row |
| row_dirty | output | 1 | The open row has been written |
| powered_down | output | 1 | Bank is in powerdown |
| rd_data_valid | output | 1 | Read data on the bus this cycle |
| wr_data_accept | output | 1 | Write data taken this cycle |
| refresh_req | output | 1 | Refresh request, constant low |

## Verification
The main function is the gating of commands by elapsed time, so the bench offers each command early and measures the cycle in which it is accepted. Four patterns are used. Back-to-back column commands after a row-open separate the row-open-to-column gap from the column-to-column gap. A write followed by a read and a close separates the write-to-read turnaround from the write-to-close gap. Closes of a clean row, a short-pulse dirty row and a long-pulse dirty row show that write-back time depends on both the dirty flag and the pulse kind. Powerdown entries after a write and after a read tell the two entry gaps apart, while probes during powerdown show that illegal commands are held, not lost. A scoreboard of expected data windows is checked every cycle against both window outputs.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  typedef enum logic [2:0] {
    OP_ACT = 3'd0,
    OP_RD  = 3'd1,
    OP_WR  = 3'd2,
    OP_PRE = 3'd3,
    OP_PDE = 3'd4,
    OP_PDX = 3'd5
  } pcm_op_e;

  localparam int TI_BANK = 0;  // bank busy: close, write-back, powerdown moves
  localparam int TI_RCD  = 1;  // row-open to column
  localparam int TI_CCD  = 2;  // column to column
  localparam int TI_WTR  = 3;  // write to read
  localparam int TI_PRE  = 4;  // column to close
  localparam int TI_PDE  = 5;  // column to powerdown entry
  localparam int NUM_TIMERS = 6;
endpackage

// File: rtl/pcm_gap_timer.sv
module pcm_gap_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         done
);
  logic [W-1:0] cnt;
  logic [W-1:0] dec;

  assign dec  = (cnt == '0) ? '0 : cnt - 1'b1;
  assign done = (cnt == '0);

  // A new load never shortens a gap already running.
  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (load && val > dec) cnt <= val;
    else                        cnt <= dec;
  end
endmodule

// File: rtl/pcm_data_window.sv
module pcm_data_window #(
  parameter int DELAY = 1,
  parameter int LEN   = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic active
);
  localparam int HW = DELAY + LEN - 1;
  logic [HW-1:0] hist;  // bit i: command issued i+1 cycles ago

  generate
    if (HW == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) hist <= '0;
        else     hist <= fire;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) hist <= '0;
        else     hist <= {hist[HW-2:0], fire};
      end
    end
  endgenerate

  assign active = |hist[HW-1:DELAY-1];
endmodule

// File: rtl/pcm_bank_tracker.sv
module pcm_bank_tracker
  import pcm_pkg::*;
#(
  parameter int ROW_W    = 16,
  parameter int CTR_W    = 8,
  parameter int T_RCD    = 48,
  parameter int T_RESET  = 40,
  parameter int T_SET    = 60,
  parameter int T_RP     = 1,
  parameter int T_CAS    = 1,
  parameter int T_BURST  = 4,
  parameter int T_CCD    = 2,
  parameter int T_CWD    = 4,
  parameter int T_WTR    = 3,
  parameter int T_RTP    = 3,
  parameter int T_RDPDEN = 5,
  parameter int T_WRPDEN = 68,
  parameter int T_PD     = 1,
  parameter int T_XP     = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [ROW_W-1:0] cmd_row,
  input  logic             cmd_set_pulse,
  output logic             cmd_ready,
  output logic             row_open,
  output logic [ROW_W-1:0] open_row,
  output logic             row_dirty,
  output logic             powered_down,
  output logic             rd_data_valid,
  output logic             wr_data_accept,
  output logic             refresh_req
);
  // Load value = gap - 1: a counter loaded at the accept edge reaches zero
  // exactly in the first cycle the follow-on command is legal.
  localparam logic [CTR_W-1:0] L_RCD    = CTR_W'(T_RCD - 1);
  localparam logic [CTR_W-1:0] L_CCD    = CTR_W'(T_CCD - 1);
  localparam logic [CTR_W-1:0] L_WTR    = CTR_W'(T_CWD + T_BURST + T_WTR - 2);
  localparam logic [CTR_W-1:0] L_PRE_RD = CTR_W'(T_RTP - 1);
  localparam logic [CTR_W-1:0] L_PRE_WR = CTR_W'(T_CWD + T_BURST - 1);
  localparam logic [CTR_W-1:0] L_PDE_RD = CTR_W'(T_RDPDEN - 1);
  localparam logic [CTR_W-1:0] L_PDE_WR = CTR_W'(T_WRPDEN - 1);
  localparam logic [CTR_W-1:0] L_CLEAN  = CTR_W'(T_RP - 1);
  localparam logic [CTR_W-1:0] L_RESET  = CTR_W'(T_RP + T_RESET - 1);
  localparam logic [CTR_W-1:0] L_SET    = CTR_W'(T_RP + T_SET - 1);
  localparam logic [CTR_W-1:0] L_PD     = CTR_W'(T_PD - 1);
  localparam logic [CTR_W-1:0] L_XP     = CTR_W'(T_XP - 1);

  logic                  fire;
  logic [NUM_TIMERS-1:0] t_load;
  logic [CTR_W-1:0]      t_val [NUM_TIMERS];
  logic [NUM_TIMERS-1:0] t_done;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_TIMERS; gi++) begin : g_timer
      pcm_gap_timer #(.W(CTR_W)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (t_load[gi]),
        .val  (t_val[gi]),
        .done (t_done[gi])
      );
    end
  endgenerate

  // Legality of the offered command
  logic col_ok;
  assign col_ok = !powered_down && row_open && t_done[TI_BANK] &&
                  t_done[TI_RCD] && t_done[TI_CCD];

  always_comb begin
    case (cmd_op)
      OP_ACT:  cmd_ready = !powered_down && !row_open && t_done[TI_BANK];
      OP_RD:   cmd_ready = col_ok && t_done[TI_WTR];
      OP_WR:   cmd_ready = col_ok;
      OP_PRE:  cmd_ready = !powered_down && t_done[TI_BANK] && t_done[TI_PRE];
      OP_PDE:  cmd_ready = !powered_down && t_done[TI_BANK] && t_done[TI_PDE];
      OP_PDX:  cmd_ready = powered_down && t_done[TI_BANK];
      default: cmd_ready = 1'b0;
    endcase
  end

  assign fire = cmd_valid && cmd_ready;

  // Timer loads per accepted command
  always_comb begin
    t_load = '0;
    for (int i = 0; i < NUM_TIMERS; i++) t_val[i] = '0;
    if (fire) begin
      case (cmd_op)
        OP_ACT: begin
          t_load[TI_RCD] = 1'b1; t_val[TI_RCD] = L_RCD;
        end
        OP_RD: begin
          t_load[TI_CCD] = 1'b1; t_val[TI_CCD] = L_CCD;
          t_load[TI_PRE] = 1'b1; t_val[TI_PRE] = L_PRE_RD;
          t_load[TI_PDE] = 1'b1; t_val[TI_PDE] = L_PDE_RD;
        end
        OP_WR: begin
          t_load[TI_CCD] = 1'b1; t_val[TI_CCD] = L_CCD;
          t_load[TI_WTR] = 1'b1; t_val[TI_WTR] = L_WTR;
          t_load[TI_PRE] = 1'b1; t_val[TI_PRE] = L_PRE_WR;
          t_load[TI_PDE] = 1'b1; t_val[TI_PDE] = L_PDE_WR;
        end
        OP_PRE: begin
          t_load[TI_BANK] = 1'b1;
          t_val[TI_BANK]  = !row_dirty ? L_CLEAN : (cmd_set_pulse ? L_SET : L_RESET);
        end
        OP_PDE: begin
          t_load[TI_BANK] = 1'b1; t_val[TI_BANK] = L_PD;
        end
        OP_PDX: begin
          t_load[TI_BANK] = 1'b1; t_val[TI_BANK] = L_XP;
        end
        default: ;
      endcase
    end
  end

  // Row buffer and power state
  always_ff @(posedge clk) begin
    if (rst) begin
      row_open     <= 1'b0;
      open_row     <= '0;
      row_dirty    <= 1'b0;
      powered_down <= 1'b0;
    end else if (fire) begin
      case (cmd_op)
        OP_ACT: begin
          row_open  <= 1'b1;
          open_row  <= cmd_row;
          row_dirty <= 1'b0;
        end
        OP_WR:  row_dirty <= 1'b1;
        OP_PRE: begin
          row_open  <= 1'b0;
          row_dirty <= 1'b0;
        end
        OP_PDE: powered_down <= 1'b1;
        OP_PDX: powered_down <= 1'b0;
        default: ;
      endcase
    end
  end

  pcm_data_window #(.DELAY(T_CAS), .LEN(T_BURST)) u_rd_win (
    .clk    (clk),
    .rst    (rst),
    .fire   (fire && cmd_op == OP_RD),
    .active (rd_data_valid)
  );

  pcm_data_window #(.DELAY(T_CWD), .LEN(T_BURST)) u_wr_win (
    .clk    (clk),
    .rst    (rst),
    .fire   (fire && cmd_op == OP_WR),
    .active (wr_data_accept)
  );

  assign refresh_req = 1'b0;
endmodule

// File: rtl/pcm_bank_tracker_chk.sv
module pcm_bank_tracker_chk
  import pcm_pkg::*;
#(
  parameter int T_RCD   = 48,
  parameter int T_CCD   = 2,
  parameter int T_CAS   = 1,
  parameter int T_BURST = 4,
  parameter int T_CWD   = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [2:0] cmd_op,
  input logic       row_open,
  input logic       row_dirty,
  input logic       powered_down,
  input logic       rd_data_valid,
  input logic       wr_data_accept
);
  logic fire, col_fire, rd_fire, wr_fire, act_fire;
  logic [7:0] since_act, since_col, since_rd, since_wr;

  assign fire     = cmd_valid && cmd_ready;
  assign act_fire = fire && cmd_op == OP_ACT;
  assign rd_fire  = fire && cmd_op == OP_RD;
  assign wr_fire  = fire && cmd_op == OP_WR;
  assign col_fire = rd_fire || wr_fire;

  function automatic logic [7:0] sat_inc(input logic [7:0] v);
    return (v == 8'hFF) ? v : v + 8'd1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      since_act <= 8'hFF;
      since_col <= 8'hFF;
      since_rd  <= 8'hFF;
      since_wr  <= 8'hFF;
    end else begin
      since_act <= act_fire ? 8'd1 : sat_inc(since_act);
      since_col <= col_fire ? 8'd1 : sat_inc(since_col);
      since_rd  <= rd_fire  ? 8'd1 : sat_inc(since_rd);
      since_wr  <= wr_fire  ? 8'd1 : sat_inc(since_wr);
    end
  end

  AST_RCD_GAP: assert property (@(posedge clk) disable iff (rst)
    col_fire |-> int'(since_act) >= T_RCD);  // R2
  AST_CCD_GAP: assert property (@(posedge clk) disable iff (rst)
    col_fire |-> int'(since_col) >= T_CCD);  // R5
  AST_RD_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (int'(since_rd) >= T_CAS && int'(since_rd) < T_CAS + T_BURST) |-> rd_data_valid);  // R4
  AST_WR_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (int'(since_wr) >= T_CWD && int'(since_wr) < T_CWD + T_BURST) |-> wr_data_accept);  // R6
  AST_WR_DIRTY: assert property (@(posedge clk) disable iff (rst)
    wr_fire |=> row_dirty);  // R7
  AST_PD_EXIT_ONLY: assert property (@(posedge clk) disable iff (rst)
    (fire && powered_down) |-> cmd_op == OP_PDX);  // R10
  AST_ACT_CLOSED: assert property (@(posedge clk) disable iff (rst)
    act_fire |-> !row_open);  // R10
endmodule

bind pcm_bank_tracker pcm_bank_tracker_chk #(
  .T_RCD(T_RCD), .T_CCD(T_CCD), .T_CAS(T_CAS), .T_BURST(T_BURST), .T_CWD(T_CWD)
) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .row_open(row_open), .row_dirty(row_dirty),
  .powered_down(powered_down), .rd_data_valid(rd_data_valid),
  .wr_data_accept(wr_data_accept)
);

// File: tb/pcm_bank_tracker_tb.sv
module pcm_bank_tracker_tb;
  localparam logic [2:0] C_ACT = 3'd0, C_RD = 3'd1, C_WR = 3'd2,
                         C_PRE = 3'd3, C_PDE = 3'd4, C_PDX = 3'd5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = C_ACT;
  logic [15:0] cmd_row = '0;
  logic        cmd_set_pulse = 1'b0;
  logic        cmd_ready, row_open, row_dirty, powered_down;
  logic        rd_data_valid, wr_data_accept, refresh_req;
  logic [15:0] open_row;

  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;
  bit refresh_seen = 0;
  bit done_flag = 0;

  typedef struct { int lo; int hi; } win_t;
  win_t rd_q[$];
  win_t wr_q[$];

  always #4 clk = ~clk;  // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  pcm_bank_tracker u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_row(cmd_row), .cmd_set_pulse(cmd_set_pulse), .cmd_ready(cmd_ready),
    .row_open(row_open), .open_row(open_row), .row_dirty(row_dirty),
    .powered_down(powered_down), .rd_data_valid(rd_data_valid),
    .wr_data_accept(wr_data_accept), .refresh_req(refresh_req)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  endtask

  // Driver: offers a command until accepted; records cycles.
  task automatic issue(input logic [2:0] op, input logic [15:0] row,
                       input logic pulse, output int pres, output int acc);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_row = row; cmd_set_pulse = pulse;
    pres = cyc;
    #1;
    while (!cmd_ready) begin
      @(negedge clk);
      #1;
    end
    acc = cyc;
    if (op == C_RD) rd_q.push_back('{acc + 1, acc + 4});
    if (op == C_WR) wr_q.push_back('{acc + 4, acc + 7});
    @(posedge clk);
    #1 cmd_valid = 1'b0;
  endtask

  task automatic check_time(input string req, input int acc, input int pres, input int earliest);
    int exp;
    exp = (pres > earliest) ? pres : earliest;
    check(acc == exp, req, acc, exp);
  endtask

  task automatic peek();
    @(negedge clk);
    #1;
  endtask

  // Monitor: compares both data windows against the scoreboard every cycle.
  always @(negedge clk) begin
    if (!rst) begin
      bit er, ew;
      #2;
      if (refresh_req) refresh_seen = 1;
      while (rd_q.size() > 0 && rd_q[0].hi < cyc) void'(rd_q.pop_front());
      while (wr_q.size() > 0 && wr_q[0].hi < cyc) void'(wr_q.pop_front());
      er = 0; ew = 0;
      foreach (rd_q[i]) if (cyc >= rd_q[i].lo && cyc <= rd_q[i].hi) er = 1;
      foreach (wr_q[i]) if (cyc >= wr_q[i].lo && cyc <= wr_q[i].hi) ew = 1;
      if (er || rd_data_valid) check(rd_data_valid == er, "R4 read window", rd_data_valid, er);
      if (ew || wr_data_accept) check(wr_data_accept == ew, "R6 write window", wr_data_accept, ew);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int p, a_act1, r1, r2, w1, r3, pr1, a2, pr2, a3, w2, pr3, a4, w3, pd1, px1, r4, pd2, px2, a;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    // R1 reset state
    check(row_open == 0 && row_dirty == 0 && powered_down == 0, "R1 flags", {row_open, row_dirty, powered_down}, 0);
    check(rd_data_valid == 0 && wr_data_accept == 0, "R1 windows", {rd_data_valid, wr_data_accept}, 0);
    cmd_op = C_RD; #1;
    check(cmd_ready == 0, "R10 read with no row", cmd_ready, 0);
    cmd_op = C_ACT; #1;
    check(cmd_ready == 1, "R1 row-open ready", cmd_ready, 1);

    issue(C_ACT, 16'h0005, 0, p, a_act1);
    check_time("R1 first row-open", a_act1, p, p);
    peek();
    check(row_open && open_row == 16'h0005 && !row_dirty, "R7 open row", open_row, 5);
    cmd_op = C_ACT; #1;
    check(cmd_ready == 0, "R10 row-open while open", cmd_ready, 0);

    issue(C_RD, 0, 0, p, r1);  check_time("R2 row-open to read", r1, p, a_act1 + 48);
    issue(C_RD, 0, 0, p, r2);  check_time("R5 read to read", r2, p, r1 + 2);
    issue(C_WR, 0, 0, p, w1);  check_time("R5 read to write", w1, p, r2 + 2);
    peek();
    check(row_dirty == 1, "R7 write sets dirty", row_dirty, 1);
    issue(C_RD, 0, 0, p, r3);  check_time("R6 write to read", r3, p, w1 + 10);
    issue(C_PRE, 0, 0, p, pr1);
    check_time("R8 close after read/write", pr1, p, (r3 + 3 > w1 + 8) ? r3 + 3 : w1 + 8);
    peek();
    check(row_open == 0 && row_dirty == 0, "R7 close clears", {row_open, row_dirty}, 0);
    issue(C_ACT, 16'h0009, 0, p, a2);  check_time("R3 short write-back", a2, p, pr1 + 41);
    issue(C_PRE, 0, 0, p, pr2);        check_time("R8 close right after open", pr2, p, a2 + 1);
    issue(C_ACT, 16'h000A, 0, p, a3);  check_time("R8 clean close 1 cycle", a3, p, pr2 + 1);
    issue(C_WR, 0, 0, p, w2);          check_time("R2 row-open to write", w2, p, a3 + 48);
    issue(C_PRE, 0, 1, p, pr3);        check_time("R8 write to close", pr3, p, w2 + 8);
    issue(C_ACT, 16'h000B, 0, p, a4);  check_time("R3 long write-back", a4, p, pr3 + 61);
    issue(C_WR, 0, 0, p, w3);          check_time("R2 row-open to write 2", w3, p, a4 + 48);
    issue(C_PDE, 0, 0, p, pd1);        check_time("R9 write to powerdown", pd1, p, w3 + 68);
    peek();
    check(powered_down == 1, "R9 powered down", powered_down, 1);
    cmd_op = C_RD; #1;
    check(cmd_ready == 0, "R10 read while down", cmd_ready, 0);
    issue(C_PDX, 0, 0, p, px1);        check_time("R9 powerdown exit", px1, p, pd1 + 1);
    issue(C_RD, 0, 0, p, r4);          check_time("R9 exit to read", r4, p, px1 + 3);
    issue(C_PDE, 0, 0, p, pd2);        check_time("R9 read to powerdown", pd2, p, r4 + 5);
    issue(C_PDX, 0, 0, p, px2);        check_time("R9 powerdown exit 2", px2, p, pd2 + 1);
    issue(C_PRE, 0, 0, p, a);          check_time("R10 held command later issued", a, p, px2 + 3);
    repeat (10) @(negedge clk);
    check(refresh_seen == 0, "R11 no refresh", refresh_seen, 0);
    finish_run();
  end
endmodule